// File: doc/BRIEF.md
# Station Address Receive Filter

This block decides, for each incoming frame, whether it is accepted by the receive path. The decision is based only on the 48-bit destination address. The address is presented together with a one-cycle valid strobe. The block compares it against a locally held station address and also checks for the broadcast address, which is all ones. It returns a registered accept/drop decision along with the class of address that was recognised.

Software programs the filter through a small register write port. Three 16-bit station words hold the station address, and the byte order across them is reversed. A filter control word enables the broadcast and perfect-match classes one at a time. A MAC configuration word carries a receive enable and a pass-all mode. Pass-all accepts every frame while reception is enabled.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every station word is zero, both accept classes are disabled, reception is disabled, and `dec_valid`, `dec_accept` and `dec_match` are all zero.
- R2: `dec_valid` is high in exactly the cycle after a cycle in which `frame_valid` was high, and low otherwise.
- R3: Destination byte k is carried on `dst_addr[8k+7:8k]`, with byte 0 being the first byte on the wire. A write to `wr_sel`=2 loads station bytes 0 (low half) and 1 (high half). `wr_sel`=1 loads bytes 2 and 3 in the same way, and `wr_sel`=0 loads bytes 4 and 5.
- R4: When the destination equals the station address and is not all ones, `dec_match` is 1 (perfect). The frame is accepted when reception is on and filter control bit 5 (`wr_sel`=3) is set.
- R5: An all-ones destination reports `dec_match`=2 (broadcast). This holds even when the station address is also all ones. The frame is accepted when reception is on and filter control bit 1 is set.
- R6: A match whose class is disabled is dropped (`dec_accept`=0), but its match type is still reported.
- R7: With MAC configuration bit 1 (`wr_sel`=4) set, every frame is accepted, including frames with `dec_match`=0, provided reception is enabled.
- R8: With MAC configuration bit 0 clear, no frame is accepted, whatever the other settings.
- R9: A destination that is neither broadcast nor the station address reports `dec_match`=0 and is dropped unless pass-all applies.
- R10: Writes with `wr_sel` of 5 to 7 change no filter setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0..2 station words, 3 filter control, 4 MAC configuration |
| wr_data | input | 16 | Register write data |
| frame_valid | input | 1 | Destination address valid strobe |
| dst_addr | input | 48 | Destination address, byte k at bits 8k+7:8k |
| dec_valid | output | 1 | Decision valid, one cycle after the strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_match | output | 2 | Match type: 0 none, 1 perfect, 2 broadcast |

## Verification
Destinations are drawn from four kinds of input: random addresses, which should almost always miss; the exact station address, which separates a perfect match from a miss; the all-ones address, which separates broadcast from perfect; and the station address with a single bit flipped, which shows that every byte comparator takes part. Each kind is presented under random mixes of the four control bits, which tells class-enable masking apart from pass-all and from the receive enable. Directed cases load distinct bytes into each station word to pin down byte order, set the station address to all ones to show that broadcast takes priority, and write to the unused selects to show that they have no effect.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned CTL_BCAST_BIT = 1;
  localparam int unsigned CTL_PERF_BIT  = 5;
  localparam int unsigned MC_RXEN_BIT   = 0;
  localparam int unsigned MC_PASS_BIT   = 1;

  typedef enum logic [1:0] {
    MT_NONE    = 2'd0,
    MT_PERFECT = 2'd1,
    MT_BCAST   = 2'd2
  } match_t;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned N_WORDS = 3,
  parameter int unsigned SEL_W   = 3,
  localparam int unsigned ADDR_W = REG_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [ADDR_W-1:0] station,
  output logic              en_bcast,
  output logic              en_perf,
  output logic              rx_en,
  output logic              pass_all
);
  import rxf_pkg::*;

  localparam int unsigned SEL_CTL = N_WORDS;
  localparam int unsigned SEL_MC  = N_WORDS + 1;

  logic [REG_W-1:0] word_q [N_WORDS];
  logic             bc_q, bc_d, pf_q, pf_d, rx_q, rx_d, pa_q, pa_d;
  logic             ctl_we, mc_we;

  assign ctl_we = wr_en && (wr_sel == SEL_W'(SEL_CTL));
  assign mc_we  = wr_en && (wr_sel == SEL_W'(SEL_MC));

  genvar gi;
  generate
    for (gi = 0; gi < N_WORDS; gi++) begin : g_word
      logic             we;
      logic [REG_W-1:0] nxt;
      assign we = wr_en && (wr_sel == SEL_W'(gi));
      always_comb begin
        nxt = word_q[gi];
        if (we) nxt = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q[gi] <= '0;
        else if (we) word_q[gi] <= nxt;
      end
      // word 0 holds the highest-numbered bytes
      assign station[(N_WORDS-1-gi)*REG_W +: REG_W] = word_q[gi];
    end
  endgenerate

  always_comb begin
    bc_d = bc_q;
    pf_d = pf_q;
    rx_d = rx_q;
    pa_d = pa_q;
    if (ctl_we) begin
      bc_d = wr_data[CTL_BCAST_BIT];
      pf_d = wr_data[CTL_PERF_BIT];
    end
    if (mc_we) begin
      rx_d = wr_data[MC_RXEN_BIT];
      pa_d = wr_data[MC_PASS_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q <= 1'b0;
      pf_q <= 1'b0;
      rx_q <= 1'b0;
      pa_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        bc_q <= bc_d;
        pf_q <= pf_d;
      end
      if (mc_we) begin
        rx_q <= rx_d;
        pa_q <= pa_d;
      end
    end
  end

  assign en_bcast = bc_q;
  assign en_perf  = pf_q;
  assign rx_en    = rx_q;
  assign pass_all = pa_q;
endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int unsigned N_BYTES = 6,
  localparam int unsigned ADDR_W = N_BYTES * rxf_pkg::BYTE_W
) (
  input  logic [ADDR_W-1:0] dst,
  input  logic [ADDR_W-1:0] station,
  output logic              is_bcast,
  output logic              is_perfect
);
  import rxf_pkg::*;

  logic [N_BYTES-1:0] byte_eq;
  logic [N_BYTES-1:0] byte_ones;

  genvar gb;
  generate
    for (gb = 0; gb < N_BYTES; gb++) begin : g_byte
      assign byte_eq[gb]   = (dst[gb*BYTE_W +: BYTE_W] == station[gb*BYTE_W +: BYTE_W]);
      assign byte_ones[gb] = &dst[gb*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign is_bcast   = &byte_ones;
  assign is_perfect = &byte_eq;
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_valid,
  input  logic       is_bcast,
  input  logic       is_perfect,
  input  logic       en_bcast,
  input  logic       en_perf,
  input  logic       rx_en,
  input  logic       pass_all,
  output logic       dec_valid,
  output logic       dec_accept,
  output logic [1:0] dec_match
);
  import rxf_pkg::*;

  logic   vld_q, vld_d, acc_q, acc_d, upd;
  match_t mt_q, mt_d;

  assign upd = frame_valid | vld_q;

  always_comb begin
    vld_d = frame_valid;
    acc_d = 1'b0;
    mt_d  = MT_NONE;
    if (frame_valid) begin
      if (is_bcast)        mt_d = MT_BCAST;
      else if (is_perfect) mt_d = MT_PERFECT;
      acc_d = rx_en && (pass_all ||
                        (is_bcast && en_bcast) ||
                        (!is_bcast && is_perfect && en_perf));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      mt_q  <= MT_NONE;
    end else if (upd) begin
      vld_q <= vld_d;
      acc_q <= acc_d;
      mt_q  <= mt_d;
    end
  end

  assign dec_valid  = vld_q;
  assign dec_accept = acc_q;
  assign dec_match  = mt_q;

  // R9 and R1: no decision means nothing is accepted and nothing is matched
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_match == 2'd0));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int unsigned N_BYTES = 6,
  parameter int unsigned REG_W   = 16,
  localparam int unsigned ADDR_W  = N_BYTES * rxf_pkg::BYTE_W,
  localparam int unsigned N_WORDS = ADDR_W / REG_W,
  localparam int unsigned SEL_W   = $clog2(N_WORDS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              frame_valid,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [1:0]        dec_match
);
  logic [ADDR_W-1:0] station;
  logic en_bcast, en_perf, rx_en, pass_all, is_bcast, is_perfect;

  rxf_regs #(.REG_W(REG_W), .N_WORDS(N_WORDS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .station(station), .en_bcast(en_bcast), .en_perf(en_perf),
    .rx_en(rx_en), .pass_all(pass_all)
  );

  rxf_match #(.N_BYTES(N_BYTES)) u_match (
    .dst(dst_addr), .station(station), .is_bcast(is_bcast), .is_perfect(is_perfect)
  );

  rxf_decide u_dec (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
    .is_bcast(is_bcast), .is_perfect(is_perfect), .en_bcast(en_bcast),
    .en_perf(en_perf), .rx_en(rx_en), .pass_all(pass_all),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_match(dec_match)
  );

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> dec_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> !dec_valid);
  a_r8_rx_off_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !rx_en) |=> !dec_accept);
  a_r7_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && rx_en && pass_all) |=> dec_accept);
  a_r5_bcast_type: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && (&dst_addr)) |=> (dec_match == 2'd2));
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk, rst_n, wr_en, frame_valid;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic [47:0] dst_addr;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_match;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_sa [3];
  logic        m_bc, m_pf, m_rx, m_pa;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .frame_valid(frame_valid), .dst_addr(dst_addr),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_match(dec_match)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [47:0] station_model();
    // R3: byte k of the address at bits 8k+7:8k; word 2 holds bytes 0,1, word 0 bytes 4,5
    logic [47:0] s;
    for (int k = 0; k < 2; k++) begin
      s[8*k +: 8]       = m_sa[2][8*k +: 8];
      s[8*(k+2) +: 8]   = m_sa[1][8*k +: 8];
      s[8*(k+4) +: 8]   = m_sa[0][8*k +: 8];
    end
    return s;
  endfunction

  function automatic logic [1:0] exp_match(logic [47:0] a);
    if (a == '1) return 2'd2;
    if (a == station_model()) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic exp_accept(logic [47:0] a);
    logic [1:0] m;
    m = exp_match(a);
    if (!m_rx) return 1'b0;
    if (m_pa) return 1'b1;
    return (m == 2'd2 && m_bc) || (m == 2'd1 && m_pf);
  endfunction

  task automatic wr(logic [2:0] sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    if (sel < 3) m_sa[sel] = d;
    else if (sel == 3) begin m_bc = d[1]; m_pf = d[5]; end
    else if (sel == 4) begin m_rx = d[0]; m_pa = d[1]; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic present(string req, logic [47:0] a);
    @(negedge clk);
    frame_valid = 1'b1; dst_addr = a;
    @(negedge clk);
    frame_valid = 1'b0;
    chk({req, " valid"}, dec_valid, 1'b1);
    chk({req, " match"}, dec_match, exp_match(a));
    chk({req, " accept"}, dec_accept, exp_accept(a));
    @(negedge clk);
    chk({req, " R2 valid drops"}, dec_valid, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'h5eed_1234));
    m_sa[0] = '0; m_sa[1] = '0; m_sa[2] = '0;
    m_bc = 0; m_pf = 0; m_rx = 0; m_pa = 0;
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; frame_valid = 0; dst_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dec_valid", dec_valid, 1'b0);
    chk("R1 dec_accept", dec_accept, 1'b0);
    chk("R1 dec_match", dec_match, 2'd0);
    // R1: zero station, classes off, reception off: zero address matches but is dropped
    present("R1 zero station", 48'h0);
    present("R8 broadcast rx off", '1);

    // R3 byte mapping with distinct bytes
    wr(3'd2, 16'h1102);
    wr(3'd1, 16'h3322);
    wr(3'd0, 16'h5544);
    wr(3'd3, 16'h0022);
    wr(3'd4, 16'h0001);
    present("R3 R4 perfect in order", 48'h5544_3322_1102);
    present("R3 reversed order misses", 48'h0211_2233_4455);
    present("R5 broadcast", '1);
    // R6 disabled classes
    wr(3'd3, 16'h0000);
    present("R6 perfect disabled", 48'h5544_3322_1102);
    present("R6 broadcast disabled", '1);
    // R7 pass-all
    wr(3'd4, 16'h0003);
    present("R7 pass-all miss", 48'h0123_4567_89ab);
    // R8 rx off with pass-all
    wr(3'd4, 16'h0002);
    present("R8 pass-all rx off", 48'h0123_4567_89ab);
    // R5 priority when station is all ones
    wr(3'd4, 16'h0001);
    wr(3'd3, 16'h0020);
    wr(3'd0, 16'hffff); wr(3'd1, 16'hffff); wr(3'd2, 16'hffff);
    present("R5 broadcast priority", '1);
    // R10 unused selects ignored
    wr(3'd2, 16'h1102); wr(3'd1, 16'h3322); wr(3'd0, 16'h5544);
    wr(3'd3, 16'h0000); wr(3'd4, 16'h0001);
    for (int s = 5; s < 8; s++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(s); wr_data = 16'hffff;
      @(negedge clk);
      wr_en = 1'b0;
    end
    present("R10 station intact, class off", 48'h5544_3322_1102);
    present("R10 pass-all still off", 48'h0000_0000_0001);

    // randomized mix
    for (int i = 0; i < 400; i++) begin
      if (i % 16 == 0) begin
        wr(3'd0, 16'($urandom)); wr(3'd1, 16'($urandom)); wr(3'd2, 16'($urandom));
        wr(3'd3, 16'($urandom)); wr(3'd4, 16'($urandom));
      end
      case ($urandom % 4)
        0: a = {16'($urandom), 32'($urandom)};
        1: a = station_model();
        2: a = '1;
        default: begin a = station_model(); a[$urandom % 48] ^= 1'b1; end
      endcase
      present("R9 random", a);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule